// File: doc/BRIEF.md
# Banked GPIO Controller with Per-Pin Interrupt Detection

This block is a memory-mapped general-purpose I/O controller. Its pins are grouped into banks of 32, and every bank has the same register set at a fixed address stride. For each pin the controller holds an output value and an output-enable bit. It also samples the pin through a two-flop synchronizer and runs the sample through an interrupt detector. The detector can be set for edge or level sensing, for either polarity, or for both edges.

Each pin's detector sets a sticky status bit, and software clears it by writing ones. Per-pin mask bits select which status bits reach the single interrupt output. That output is the OR of every enabled status bit in all banks, registered once. Software reaches everything through a plain 32-bit write/read port that uses byte addresses. Reads are combinational from registered state. The last bank may hold fewer than 32 pins.

Top module: `gpio_event_ctrl`

## Requirements
- R1: After a synchronous reset, every register reads zero, no pin is driven (`pins_oe` and `pins_out` zero) and `irq_out` is low.
- R2: Bank n occupies byte addresses n*0x200 + offset. The offsets are 0x00 synchronized input (read only), 0x04 output value, 0x08 output enable, 0x0c sense type, 0x10 both-edges, 0x14 polarity, 0x18 mask, 0x1c raw status (read only), 0x20 masked status (read only) and 0x24 clear (write only, reads 0). Bit i of a register belongs to pin 32*n+i. Bits above the last pin of a partial bank read 0.
- R3: Offset 0x00 returns the pin inputs after a two-flop synchronizer. A change on an input is visible there within three clock cycles.
- R4: `pins_oe` equals the output-enable register. Each `pins_out` bit equals its output value when output enable is 1 and is 0 otherwise.
- R5: With sense type 0 and both-edges 0, polarity 1 sets a pin's status on a rising edge of its synchronized input, and polarity 0 sets it on a falling edge.
- R6: With sense type 0 and both-edges 1, every edge in either direction sets the status, whatever the polarity bit says.
- R7: With sense type 1, the status is set in every cycle in which the synchronized input equals the polarity bit (1 = high, 0 = low). A clear therefore does not stay in effect while that level persists.
- R8: Masked status reads raw status AND mask. A mask bit of 1 enables the pin's interrupt.
- R9: Writing 1 to a bit of the clear register clears that status bit. Bits written 0 are unchanged. A status bit never falls without such a write.
- R10: When a detected event and a clear of the same bit fall in the same cycle, the bit stays set.
- R11: `irq_out` is the OR of all masked status bits of all banks, delayed by one register stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_wr | input | 1 | Write strobe for the register port |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| pins_in | input | NUM_PINS | Asynchronous pin inputs |
| pins_out | output | NUM_PINS | Pin output values, gated by output enable |
| pins_oe | output | NUM_PINS | Pin output enables |
| irq_out | output | 1 | Combined interrupt request |

## Verification
The assertions assume that reset is held from time zero until the first edges. They also assume that `bus_wr` low means no clear can reach any bank, so any status bit that falls in such a cycle is an error. The edge-cause check assumes that an edge-mode status bit can only rise after the synchronized input differed from its previous sample. The stimulus changes pins only at falling clock edges. It holds each level long enough to cross the synchronizer, and it issues every clear as an explicit single-cycle write. In the one test where a clear must meet an event, the clear write is placed in the exact cycle of the edge pulse.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    localparam int PINS_PER_BANK = 32;
    localparam int STRIDE_LSB    = 9;
    localparam int OFFS_W        = STRIDE_LSB;

    typedef enum logic [OFFS_W-1:0] {
        OFS_SAMPLE = 9'h000,
        OFS_DRIVE  = 9'h004,
        OFS_ENABLE = 9'h008,
        OFS_SENSE  = 9'h00c,
        OFS_BOTH   = 9'h010,
        OFS_POLAR  = 9'h014,
        OFS_MASK   = 9'h018,
        OFS_RAW    = 9'h01c,
        OFS_MSTAT  = 9'h020,
        OFS_CLEAR  = 9'h024
    } reg_ofs_e;

    typedef struct packed {
        logic level;   // 1: level sensing, 0: edge sensing
        logic both;    // 1: any edge
        logic hi;      // 1: rising / high, 0: falling / low
    } trig_cfg_t;

    function automatic int bank_width(input int n_pins, input int bank);
        int rem;
        rem = n_pins - bank * PINS_PER_BANK;
        return (rem > PINS_PER_BANK) ? PINS_PER_BANK : rem;
    endfunction

    function automatic logic trig_event(input trig_cfg_t c, input logic cur,
                                        input logic prev);
        logic rise, fall;
        rise = cur & ~prev;
        fall = ~cur & prev;
        if (c.level)
            return c.hi ? cur : ~cur;
        else if (c.both)
            return rise | fall;
        else
            return c.hi ? rise : fall;
    endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/gpio_trigger.sv
module gpio_trigger
    import gpio_bank_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] cur,
    input  logic [W-1:0] prev,
    input  logic [W-1:0] level,
    input  logic [W-1:0] both,
    input  logic [W-1:0] hi,
    output logic [W-1:0] evt
);
    for (genvar i = 0; i < W; i++) begin : g_pin
        trig_cfg_t cfg;
        assign cfg    = trig_cfg_t'({level[i], both[i], hi[i]});
        assign evt[i] = trig_event(cfg, cur[i], prev[i]);
    end
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
    import gpio_bank_pkg::*;
#(
    parameter int W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [OFFS_W-1:0] ofs,
    input  logic [W-1:0]      wdata,
    input  logic [W-1:0]      pin_in,
    output logic [31:0]       rdata,
    output logic [W-1:0]      pin_drv,
    output logic [W-1:0]      pin_oe,
    output logic              pend,
    output logic [W-1:0]      raw_o,
    output logic [W-1:0]      mask_o,
    output logic [W-1:0]      level_o,
    output logic [W-1:0]      sync_o,
    output logic [W-1:0]      prev_o
);
    logic [W-1:0] drive_q, oe_q, level_q, both_q, hi_q, mask_q, raw_q, prev_q;
    logic [W-1:0] sync_q, evt, clr;

    gpio_sync #(.W(W)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pin_in),
        .q   (sync_q)
    );

    gpio_trigger #(.W(W)) u_trig (
        .cur   (sync_q),
        .prev  (prev_q),
        .level (level_q),
        .both  (both_q),
        .hi    (hi_q),
        .evt   (evt)
    );

    assign clr = (wr_en && ofs == OFS_CLEAR) ? wdata : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            drive_q <= '0;
            oe_q    <= '0;
            level_q <= '0;
            both_q  <= '0;
            hi_q    <= '0;
            mask_q  <= '0;
            raw_q   <= '0;
            prev_q  <= '0;
        end else begin
            prev_q <= sync_q;
            raw_q  <= (raw_q & ~clr) | evt;
            if (wr_en) begin
                case (ofs)
                    OFS_DRIVE:  drive_q <= wdata;
                    OFS_ENABLE: oe_q    <= wdata;
                    OFS_SENSE:  level_q <= wdata;
                    OFS_BOTH:   both_q  <= wdata;
                    OFS_POLAR:  hi_q    <= wdata;
                    OFS_MASK:   mask_q  <= wdata;
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        case (ofs)
            OFS_SAMPLE: rdata = 32'(sync_q);
            OFS_DRIVE:  rdata = 32'(drive_q);
            OFS_ENABLE: rdata = 32'(oe_q);
            OFS_SENSE:  rdata = 32'(level_q);
            OFS_BOTH:   rdata = 32'(both_q);
            OFS_POLAR:  rdata = 32'(hi_q);
            OFS_MASK:   rdata = 32'(mask_q);
            OFS_RAW:    rdata = 32'(raw_q);
            OFS_MSTAT:  rdata = 32'(raw_q & mask_q);
            default:    rdata = 32'd0;
        endcase
    end

    assign pin_drv = drive_q & oe_q;
    assign pin_oe  = oe_q;
    assign pend    = |(raw_q & mask_q);
    assign raw_o   = raw_q;
    assign mask_o  = mask_q;
    assign level_o = level_q;
    assign sync_o  = sync_q;
    assign prev_o  = prev_q;
endmodule

// File: rtl/gpio_event_ctrl.sv
module gpio_event_ctrl
    import gpio_bank_pkg::*;
#(
    parameter int NUM_PINS = 40,
    parameter int ADDR_W   = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         bus_rdata,
    input  logic [NUM_PINS-1:0] pins_in,
    output logic [NUM_PINS-1:0] pins_out,
    output logic [NUM_PINS-1:0] pins_oe,
    output logic                irq_out
);
    localparam int BANKS = (NUM_PINS + PINS_PER_BANK - 1) / PINS_PER_BANK;
    localparam int IDX_W = ADDR_W - STRIDE_LSB;

    logic [IDX_W-1:0]    bank_idx;
    logic [OFFS_W-1:0]   ofs;
    logic [31:0]         bank_rd [BANKS];
    logic [BANKS-1:0]    bank_pend;
    logic                irq_comb;

    logic [NUM_PINS-1:0] raw_all, mask_all, level_all, sync_all, prev_all;

    assign bank_idx = bus_addr[ADDR_W-1:STRIDE_LSB];
    assign ofs      = bus_addr[STRIDE_LSB-1:0];

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        localparam int BW = bank_width(NUM_PINS, b);
        localparam int LO = b * PINS_PER_BANK;
        logic sel;
        assign sel = bus_wr && (bank_idx == IDX_W'(b));

        gpio_bank #(.W(BW)) u_bank (
            .clk     (clk),
            .rst     (rst),
            .wr_en   (sel),
            .ofs     (ofs),
            .wdata   (bus_wdata[BW-1:0]),
            .pin_in  (pins_in[LO +: BW]),
            .rdata   (bank_rd[b]),
            .pin_drv (pins_out[LO +: BW]),
            .pin_oe  (pins_oe[LO +: BW]),
            .pend    (bank_pend[b]),
            .raw_o   (raw_all[LO +: BW]),
            .mask_o  (mask_all[LO +: BW]),
            .level_o (level_all[LO +: BW]),
            .sync_o  (sync_all[LO +: BW]),
            .prev_o  (prev_all[LO +: BW])
        );
    end

    always_comb begin
        bus_rdata = 32'd0;
        for (int b = 0; b < BANKS; b++)
            if (bank_idx == IDX_W'(b))
                bus_rdata = bank_rd[b];
    end

    assign irq_comb = |bank_pend;

    always_ff @(posedge clk) begin
        if (rst) irq_out <= 1'b0;
        else     irq_out <= irq_comb;
    end
endmodule

// File: rtl/gpio_event_chk.sv
module gpio_event_chk #(
    parameter int N = 40
) (
    input logic         clk,
    input logic         rst,
    input logic         bus_wr,
    input logic         irq_out,
    input logic         irq_comb,
    input logic [N-1:0] raw,
    input logic [N-1:0] mask,
    input logic [N-1:0] level,
    input logic [N-1:0] sync_s,
    input logic [N-1:0] prev_s
);
    AST_IRQ_ONE_STAGE: assert property (@(posedge clk) disable iff (rst)
        irq_out == $past(irq_comb));  // R11

    AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (rst)
        !bus_wr |=> (($past(raw) & ~raw) == '0));  // R9

    AST_MASK_BLOCKS_IRQ: assert property (@(posedge clk) disable iff (rst)
        ($past(mask) == '0) |-> !irq_out);  // R8

    AST_EDGE_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
        ((raw & ~$past(raw) & ~$past(level) & ~($past(sync_s) ^ $past(prev_s))) == '0));  // R5
endmodule

bind gpio_event_ctrl gpio_event_chk #(.N(NUM_PINS)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .bus_wr   (bus_wr),
    .irq_out  (irq_out),
    .irq_comb (irq_comb),
    .raw      (raw_all),
    .mask     (mask_all),
    .level    (level_all),
    .sync_s   (sync_all),
    .prev_s   (prev_all)
);

// File: tb/gpio_event_ctrl_test.sv
module gpio_event_ctrl_test;
    localparam int NP = 40;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          bus_wr = 1'b0;
    logic [15:0]   bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NP-1:0] pins_in = '0;
    logic [NP-1:0] pins_out, pins_oe;
    logic          irq_out;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    always #10 clk = ~clk;

    gpio_event_ctrl #(.NUM_PINS(NP), .ADDR_W(16)) uut (
        .clk, .rst, .bus_wr, .bus_addr, .bus_wdata, .bus_rdata,
        .pins_in, .pins_out, .pins_oe, .irq_out
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rchk(input string tag, input logic [15:0] a, input logic [31:0] exp);
        @(negedge clk);
        bus_addr = a;
        #2 chk(tag, 64'(bus_rdata), 64'(exp));
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1: reset state across every offset of both banks
        for (int o = 0; o < 10; o++) begin
            rchk("R1 bank0", 16'(o * 4), 32'd0);
            rchk("R1 bank1", 16'(16'h200 + o * 4), 32'd0);
        end
        chk("R1 irq", 64'(irq_out), 64'd0);
        chk("R1 oe", 64'(pins_oe), 64'd0);
        chk("R1 out", 64'(pins_out), 64'd0);

        // R2: read-back of every writable offset in bank 0
        for (int o = 1; o <= 6; o++) begin
            logic [31:0] pat;
            pat = 32'h9E37_79B9 * 32'(o) ^ 32'h0F0F_3355;
            wr(16'(o * 4), pat);
            rchk("R2 readback", 16'(o * 4), pat);
            wr(16'(o * 4), 32'd0);
        end
        // R2: partial bank keeps only 8 bits; clear reads zero; unmapped bank reads zero
        wr(16'h204, 32'hFFFF_FF3C);
        rchk("R2 partial bank", 16'h204, 32'h0000_003C);
        wr(16'h224, 32'hFFFF_FFFF);
        rchk("R2 clear reads 0", 16'h224, 32'd0);
        wr(16'h404, 32'hFFFF_FFFF);
        rchk("R2 unmapped bank", 16'h404, 32'd0);

        // R4: output gating
        wr(16'h004, 32'hA5A5_F00F);
        wr(16'h008, 32'h0000_FFFF);
        wr(16'h208, 32'h0000_00FF);
        idle(1);
        chk("R4 pins_out", 64'(pins_out), 64'h3C_0000_F00F);
        chk("R4 pins_oe", 64'(pins_oe), 64'hFF_0000_FFFF);
        wr(16'h008, 32'd0);
        idle(1);
        chk("R4 oe off", 64'(pins_out), 64'h3C_0000_0000);

        // R3: synchronized input
        pins_in = 40'hC3_1234_ABCD;
        idle(3);
        rchk("R3 bank0 in", 16'h000, 32'h1234_ABCD);
        rchk("R3 bank1 in", 16'h200, 32'h0000_00C3);
        pins_in = '0;
        idle(4);
        wr(16'h024, 32'hFFFF_FFFF);
        wr(16'h224, 32'hFFFF_FFFF);

        // modes on bank0: pin0 rise, pin1 fall, pin2 both(pol0), pin3 high level,
        // pin4 low level, pin5 both(pol1)
        wr(16'h00c, 32'h18);
        wr(16'h010, 32'h24);
        wr(16'h014, 32'h29);
        idle(4);
        wr(16'h024, 32'hFFFF_FFFF);
        idle(1);
        rchk("R7 low level reasserts", 16'h01c, 32'h10);
        pins_in[5:0] = 6'h3F;
        idle(5);
        rchk("R5 R6 rising sweep", 16'h01c, 32'h3D);
        wr(16'h024, 32'hFFFF_FFFF);
        idle(2);
        rchk("R7 high level reasserts", 16'h01c, 32'h08);
        pins_in[5:0] = 6'h00;
        idle(5);
        rchk("R5 R6 falling sweep", 16'h01c, 32'h3E);
        wr(16'h024, 32'hFFFF_FFFF);
        idle(2);
        rchk("R7 after clear", 16'h01c, 32'h10);

        // R8: mask and masked status
        wr(16'h018, 32'h12);
        idle(2);
        rchk("R8 masked", 16'h020, 32'h10);
        chk("R8 irq on", 64'(irq_out), 64'd1);
        wr(16'h018, 32'h0);
        idle(2);
        rchk("R8 masked off", 16'h020, 32'h0);
        chk("R8 irq off", 64'(irq_out), 64'd0);

        // R9: write-one-to-clear
        pins_in[0] = 1'b1;
        idle(5);
        rchk("R9 set", 16'h01c, 32'h11);
        wr(16'h024, 32'h0);
        rchk("R9 zero write no effect", 16'h01c, 32'h11);
        wr(16'h024, 32'h1);
        rchk("R9 one bit cleared", 16'h01c, 32'h10);

        // R10: clear in the same cycle as a rising-edge event
        pins_in[0] = 1'b0;
        idle(4);
        pins_in[0] = 1'b1;
        idle(4);
        pins_in[0] = 1'b0;
        idle(4);
        rchk("R10 preset", 16'h01c, 32'h11);
        @(negedge clk); pins_in[0] = 1'b1;
        @(posedge clk);
        @(negedge clk);
        @(posedge clk);
        @(negedge clk); bus_wr = 1'b1; bus_addr = 16'h024; bus_wdata = 32'h1;
        @(posedge clk);
        @(negedge clk); bus_wr = 1'b0;
        rchk("R10 event wins", 16'h01c, 32'h11);
        wr(16'h024, 32'h1);
        rchk("R10 later clear", 16'h01c, 32'h10);

        // R11: interrupt from the second bank, one-stage delay
        wr(16'h214, 32'h1);
        wr(16'h218, 32'h1);
        pins_in[32] = 1'b1;
        idle(6);
        chk("R11 irq from bank1", 64'(irq_out), 64'd1);
        @(negedge clk); bus_wr = 1'b1; bus_addr = 16'h224; bus_wdata = 32'h1;
        @(posedge clk);
        @(negedge clk); bus_wr = 1'b0;
        chk("R11 irq still registered", 64'(irq_out), 64'd1);
        @(negedge clk);
        chk("R11 irq dropped", 64'(irq_out), 64'd0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule